// File: doc/BRIEF.md
# Sound Decoder Control Port (I2C Slave Register Bank)

This block is the serial control port of a television sound decoder. It listens on a two-wire I2C bus as a slave and writes the received bytes into a small bank of 8-bit configuration registers that steer the decoder's analog paths. It can also answer with one status byte that reports the two signal detectors of the decoder. SCL and SDA are sampled with the system clock, which must run at least 20 times faster than SCL, and SDA is driven as an open-drain output.

A write frame carries the device address, a sub-address byte and one or more data bytes. Bits 6 to 0 of the sub-address pick the register. Bit 7 selects how a burst of data bytes is stored. When it is 0, the register index steps forward after each byte. When it is 1, every byte overwrites the same register. A read frame returns the detector status byte, and it returns that byte again for as long as the master keeps acknowledging.

Top module: `snd_i2c_ctrl`

## Requirements
- R1: After reset all configuration registers read 0 and SDA is released (`sda_oe_o` = 0).
- R2: A write frame addressed to 7-bit address 0x5B (address byte 0xB6) stores a single data byte into the register its sub-address names. The cfg_o slots are: [7:0] = sub-address 0x00, [15:8] = 0x01, [23:16] = 0x02, [31:24] = 0x05, [39:32] = 0x06.
- R3: With sub-address bit 7 = 0, each further data byte in a burst goes to the next sub-address.
- R4: With sub-address bit 7 = 1, every data byte in a burst is written to the same sub-address, and the last byte remains.
- R5: During auto-increment, the sub-address wraps from 0x7F to 0x00.
- R6: A write to a sub-address other than 0x00, 0x01, 0x02, 0x05 or 0x06 is acknowledged but changes no register.
- R7: When the address byte does not match 0x5B, the slave gives no acknowledge, releases SDA and ignores every byte until the next START.
- R8: A read frame (address byte 0xB7) returns a status byte with bit 7 = pilot detect, bit 6 = SAP detect and bits 5..0 = 0. The byte is repeated while the master acknowledges. The slave changes SDA only while SCL is low.
- R9: A repeated START at any point, including in the middle of a byte, aborts the current frame and restarts address reception. No partial data is written.
- R10: A STOP releases SDA and returns the slave to idle. Bytes sent after it without a START are neither acknowledged nor stored.
- R11: The slave pulls SDA low during the ninth clock of every byte it accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| pilot_det_i | input | 1 | Stereo pilot detector flag |
| sap_det_i | input | 1 | Second audio carrier detector flag |
| cfg_o | output | 40 | Configuration registers, five 8-bit slots |

## Verification
The bench sends bursts that cross the unimplemented gap between 0x02 and 0x05, and a burst that wraps past 0x7F. A design that counted only implemented registers, or that failed to wrap, would land these bytes in the wrong slots. It breaks frames with a repeated START right after the sub-address and after four data bits. A design that committed partial bytes, or that kept its old sub-address, would change register 0x00 or 0x05. Mismatched addresses, and bytes sent after a STOP with no START, must draw no acknowledge and no write. A design that kept decoding after either would acknowledge or store them. Reads with each detector set alone separate the two status bits, and a two-byte read checks that the master's acknowledge reloads the status.

// File: rtl/snd_i2c_pkg.sv
package snd_i2c_pkg;
  localparam int DW       = 8;
  localparam int SUB_W    = 7;
  localparam int NUM_REGS = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_READ,
    ST_READ_ACK,
    ST_IGNORE
  } bus_state_e;

  // sub-address held by each register slot
  function automatic logic [SUB_W-1:0] slot_addr(input int k);
    case (k)
      0:       return 7'h00;
      1:       return 7'h01;
      2:       return 7'h02;
      3:       return 7'h05;
      default: return 7'h06;
    endcase
  endfunction
endpackage

// File: rtl/snd_i2c_sync.sv
module snd_i2c_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/snd_i2c_engine.sv
module snd_i2c_engine
  import snd_i2c_pkg::*;
#(
  parameter logic [SUB_W-1:0] DEV_ADDR = 7'h5B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic [DW-1:0]    status_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [SUB_W-1:0] wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output bus_state_e       state_o,
  output logic             start_o,
  output logic             stop_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  bus_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [DW-1:0]    sh_q, tx_q;
  logic [SUB_W-1:0] ptr_q;
  logic             renew_q, rw_q, mack_q, oe_q;
  logic             scl_p_q, sda_p_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_s_i & ~scl_p_q;
  assign scl_fall  = ~scl_s_i & scl_p_q;
  assign start_det = scl_s_i & scl_p_q & sda_p_q & ~sda_s_i;
  assign stop_det  = scl_s_i & scl_p_q & ~sda_p_q & sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      renew_q   <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      scl_p_q   <= 1'b1;
      sda_p_q   <= 1'b1;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      scl_p_q <= scl_s_i;
      sda_p_q <= sda_s_i;
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              cnt_q <= '0;
              case (state_q)
                ST_ADDR: begin
                  if (sh_q[DW-1:1] == DEV_ADDR) begin
                    oe_q    <= 1'b1;
                    rw_q    <= sh_q[0];
                    state_q <= ST_ADDR_ACK;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                ST_SUB: begin
                  ptr_q   <= sh_q[SUB_W-1:0];
                  renew_q <= sh_q[DW-1];
                  oe_q    <= 1'b1;
                  state_q <= ST_SUB_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= sh_q;
                  if (!renew_q) ptr_q <= ptr_q + 1'b1;
                  oe_q    <= 1'b1;
                  state_q <= ST_DATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= status_i;
                oe_q    <= ~status_i[DW-1];
                state_q <= ST_READ;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_DATA;
            end
          end
          ST_READ: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST) begin
                oe_q    <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_READ_ACK;
              end else begin
                tx_q <= {tx_q[DW-2:0], 1'b0};
                oe_q <= ~tx_q[DW-2];
              end
            end
          end
          ST_READ_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q    <= status_i;
                oe_q    <= ~status_i[DW-1];
                cnt_q   <= '0;
                state_q <= ST_READ;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign state_o  = state_q;
  assign start_o  = start_det;
  assign stop_o   = stop_det;
endmodule

// File: rtl/snd_i2c_regbank.sv
module snd_i2c_regbank
  import snd_i2c_pkg::*;
#(
  parameter int N = NUM_REGS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SUB_W-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [N*DW-1:0]  cfg_o
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam logic [SUB_W-1:0] SLOT_ADDR = slot_addr(k);
    logic [DW-1:0] val_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 val_q <= '0;
      else if (wr_en_i && wr_addr_i == SLOT_ADDR)  val_q <= wr_data_i;
    end

    assign cfg_o[k*DW +: DW] = val_q;
  end
endmodule

// File: rtl/snd_i2c_ctrl.sv
module snd_i2c_ctrl
  import snd_i2c_pkg::*;
#(
  parameter logic [SUB_W-1:0] DEV_ADDR = 7'h5B,
  parameter int               N_REGS   = NUM_REGS,
  parameter int               SYNC_STG = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 pilot_det_i,
  input  logic                 sap_det_i,
  output logic [N_REGS*DW-1:0] cfg_o
);
  localparam int CFG_W = N_REGS * DW;

  logic [1:0]       bus_s, det_s;
  logic [DW-1:0]    status;
  logic             wr_en, start_det, stop_det;
  logic [SUB_W-1:0] wr_addr;
  logic [DW-1:0]    wr_data;
  bus_state_e       state;

  snd_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) i_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  snd_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(2'b00)) i_det_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pilot_det_i, sap_det_i}),
    .q_o   (det_s)
  );

  assign status = {det_s, {(DW-2){1'b0}}};

  snd_i2c_engine #(.DEV_ADDR(DEV_ADDR)) i_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_s_i  (bus_s[1]),
    .sda_s_i  (bus_s[0]),
    .status_i (status),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .state_o  (state),
    .start_o  (start_det),
    .stop_o   (stop_det)
  );

  snd_i2c_regbank #(.N(N_REGS)) i_regbank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .cfg_o    (cfg_o)
  );
endmodule

// File: rtl/snd_i2c_ctrl_chk.sv
module snd_i2c_ctrl_chk
  import snd_i2c_pkg::*;
#(
  parameter int CW = 40
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          sda_oe_i,
  input logic          start_i,
  input logic          stop_i,
  input bus_state_e    state_i,
  input logic          wr_en_i,
  input logic [CW-1:0] cfg_i
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_i) && !$past(start_i || stop_i)) |-> !scl_s_i); // R8
  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IGNORE |-> !sda_oe_i); // R7
  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == ST_ADDR && !sda_oe_i)); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == ST_IDLE && !sda_oe_i)); // R10
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> $past(wr_en_i)); // R6
endmodule

bind snd_i2c_ctrl snd_i2c_ctrl_chk #(.CW(CFG_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_s_i (bus_s[1]),
  .sda_oe_i(sda_oe_o),
  .start_i (start_det),
  .stop_i  (stop_det),
  .state_i (state),
  .wr_en_i (wr_en),
  .cfg_i   (cfg_o)
);

// File: tb/test_snd_i2c_ctrl.sv
module test_snd_i2c_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;   // system clocks per quarter SCL bit
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        pilot = 1'b0, sap = 1'b0;
  logic        sda_oe;
  logic [39:0] cfg;
  wire         sda_line = m_sda & ~sda_oe;

  int checks = 0, failures = 0;
  logic [7:0] mdl [128];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_i2c_ctrl i_snd_i2c_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .pilot_det_i(pilot),
    .sap_det_i  (sap),
    .cfg_o      (cfg)
  );

  task automatic check_val(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs observed bus results with expectations
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_val(t, {32'h0, o}, {32'h0, e});
      end
    end
  end

  function automatic logic implemented(input logic [6:0] a);
    return a == 7'h00 || a == 7'h01 || a == 7'h02 || a == 7'h05 || a == 7'h06;
  endfunction

  function automatic logic [39:0] exp_cfg();
    return {mdl[6], mdl[5], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wait_q();
    m_scl = 1'b1; wait_q(); wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    b = sda_line; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
    repeat (8) @(negedge clk);
  endtask

  // driver: push expected acknowledge (0 = acked), then observe it
  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string tag);
    logic a;
    exp_q.push_back({7'h0, ~exp_ack});
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    obs_q.push_back({7'h0, a});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
    logic [7:0] d;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_in(b);
      d[i] = b;
    end
    obs_q.push_back(d);
    bit_out(~mack);
  endtask

  task automatic wr_frame(input logic [7:0] sub, input logic [31:0] bytes, input int n, input string tag);
    logic [6:0] a;
    i2c_start();
    send_byte({7'h5B, 1'b0}, 1'b1, "R11");
    send_byte(sub, 1'b1, tag);
    a = sub[6:0];
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = bytes[8*i +: 8];
      send_byte(b, 1'b1, tag);
      if (implemented(a)) mdl[a] = b;
      if (!sub[7]) a = a + 7'd1;
    end
    i2c_stop();
    check_val(tag, cfg, exp_cfg());
  endtask

  task automatic rd_status(input logic p, input logic s, input int n);
    pilot = p; sap = s;
    repeat (8) @(negedge clk);
    i2c_start();
    send_byte({7'h5B, 1'b1}, 1'b1, "R8");
    for (int i = 0; i < n; i++) recv_byte({p, s, 6'b0}, i != n - 1, "R8");
    i2c_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    check_val("R1", cfg, 40'h0);
    check_val("R1", {39'h0, sda_oe}, 40'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_val("R1", cfg, 40'h0);

    wr_frame(8'h00, 32'h000000A5, 1, "R2");
    wr_frame(8'h00, 32'h00332211, 3, "R3");
    wr_frame(8'h04, 32'h00665544, 3, "R3");
    wr_frame(8'h81, 32'h00030201, 3, "R4");
    wr_frame(8'h7F, 32'h00008877, 2, "R5");
    wr_frame(8'h03, 32'h000000FF, 1, "R6");
    wr_frame(8'h90, 32'h0000ABCD, 2, "R6");

    // R7: foreign address
    i2c_start();
    send_byte({7'h5A, 1'b0}, 1'b0, "R7");
    send_byte(8'h00, 1'b0, "R7");
    send_byte(8'hEE, 1'b0, "R7");
    i2c_stop();
    check_val("R7", cfg, exp_cfg());

    // R8: status reads
    rd_status(1'b1, 1'b0, 1);
    rd_status(1'b0, 1'b1, 1);
    rd_status(1'b1, 1'b1, 2);
    pilot = 1'b0; sap = 1'b0;

    // R9: repeated START after sub-address, then mid data byte
    i2c_start();
    send_byte({7'h5B, 1'b0}, 1'b1, "R9");
    send_byte(8'h05, 1'b1, "R9");
    i2c_start();
    send_byte({7'h5B, 1'b0}, 1'b1, "R9");
    send_byte(8'h06, 1'b1, "R9");
    send_byte(8'h5C, 1'b1, "R9");
    mdl[6] = 8'h5C;
    i2c_stop();
    check_val("R9", cfg, exp_cfg());
    i2c_start();
    send_byte({7'h5B, 1'b0}, 1'b1, "R9");
    send_byte(8'h00, 1'b1, "R9");
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    i2c_start();
    send_byte({7'h5B, 1'b0}, 1'b1, "R9");
    send_byte(8'h02, 1'b1, "R9");
    send_byte(8'h9E, 1'b1, "R9");
    mdl[2] = 8'h9E;
    i2c_stop();
    check_val("R9", cfg, exp_cfg());

    // R10: STOP mid frame, then bytes with no START
    i2c_start();
    send_byte({7'h5B, 1'b0}, 1'b1, "R10");
    send_byte(8'h01, 1'b1, "R10");
    i2c_stop();
    check_val("R10", {39'h0, sda_oe}, 40'h0);
    send_byte({7'h5B, 1'b0}, 1'b0, "R10");
    send_byte(8'h42, 1'b0, "R10");
    m_sda = 1'b1; wait_q();
    check_val("R10", cfg, exp_cfg());

    wr_frame(8'h01, 32'h0000003C, 1, "R2");

    repeat (20) @(negedge clk);
    check_val("R8", {32'h0, 8'(exp_q.size())}, 40'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule